// File: doc/BRIEF.md
# Frame-Counted Codec Reset Sequencer

This block sequences reset and power-down for the digital core of a multi-channel audio codec. A software run bit asks the core to leave or enter power-down. The block does not act on that request at once. It counts frame strobes, which arrive as a single-cycle pulse once per sample frame, and it moves the internal core reset only after a fixed number of them. Entering power-down and leaving it use different counts.

When the core is released, the ADC runs a long initialisation phase, also counted in frames. During that phase, and during any power-down, the ADC output is forced to zero. Two zero-detect flags rise at once on a power-down request and fall on their own later frame schedule after a run request. The serial data output is held low while the core is in reset.

Every count advances only on a frame strobe. If the frame clocks stop while the core is in reset, the sequencer freezes. If the software bit reverses before a pending count ends, the count starts again for the new direction and the outputs do not change in between.

The core phase machine has five states:
- `PH_DOWN`: the core is held in reset.
- `PH_EXIT_WAIT`: a run request is waiting out its frames.
- `PH_INIT`: the ADC is initialising.
- `PH_RUN`: normal operation.
- `PH_ENTRY_WAIT`: a power-down request is waiting out its frames, and the core is still running.

Its transitions are:
- DOWN→EXIT_WAIT on a rise of the run bit.
- EXIT_WAIT→INIT on the 2nd strobe.
- EXIT_WAIT→DOWN on a fall of the run bit.
- INIT→RUN on the 516th strobe.
- INIT→ENTRY_WAIT and RUN→ENTRY_WAIT on a fall of the run bit.
- ENTRY_WAIT→DOWN on the 5th strobe.
- ENTRY_WAIT→RUN or ENTRY_WAIT→INIT on a rise of the run bit. The state it returns to depends on whether initialisation had already finished.

Each zero-detect flag has its own timer with three states:
- `ZF_HOLD`: the flag is high.
- `ZF_WAIT`: a run request is counting frames, and the flag is still high.
- `ZF_CLEAR`: the flag is low.

Its transitions are:
- HOLD→WAIT on a rise of the run bit.
- WAIT→CLEAR on the 7th strobe.
- WAIT→HOLD and CLEAR→HOLD on a fall of the run bit.

Top module: `codec_rst_seq`

## Requirements
- R1: After the hard reset, the outputs are as follows: `core_rst_n`=0, `adc_init_busy`=0, `adc_zero_force`=1, both `zero_flag` bits=1, `sdo_force_low`=1 and `core_ready`=0.
- R2: A change of `soft_run` from 1 to 0 is seen at the first clock edge where it reads 0, and a strobe in that same cycle is not counted. `core_rst_n` stays 1 through the next 4 strobes and falls at the clock edge of the 5th.
- R3: A change of `soft_run` from 0 to 1 is seen the same way. `core_rst_n` stays 0 through the 1st strobe and rises at the edge of the 2nd.
- R4: From the release of `core_rst_n`, `adc_init_busy` stays 1 for 516 strobes. At the 516th strobe edge it falls and `core_ready` rises.
- R5: `adc_zero_force` is 1 in every phase except normal operation.
- R6: Both `zero_flag` bits go to 1 at the clock edge where a fall of `soft_run` is seen.
- R7: After a rise of `soft_run`, both `zero_flag` bits stay 1 through 6 strobes and fall at the edge of the 7th.
- R8: `sdo_force_low` is 1 exactly while `core_rst_n` is 0.
- R9: A reversal of `soft_run` before a pending count ends restarts the count for the new direction, with no change of `core_rst_n` in between. A cancelled power-down returns to normal operation if initialisation had finished. Otherwise the initialisation count resumes where it was frozen.
- R10: While no strobe arrives and `soft_run` is steady, no output changes.
- R11: `core_ready` is 1 only while `core_rst_n` is 1 and initialisation has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low; the only source that clears all state |
| soft_run | input | 1 | Software run bit: 1 requests operation, 0 requests power-down |
| frame_stb | input | 1 | One-cycle pulse per sample frame |
| core_rst_n | output | 1 | Internal core reset, active low |
| adc_init_busy | output | 1 | ADC initialisation in progress |
| adc_zero_force | output | 1 | Forces the ADC digital output to zero data |
| zero_flag | output | NUM_ZFLAGS (2) | Zero-detect flags, high while forced |
| sdo_force_low | output | 1 | Holds the serial data output low |
| core_ready | output | 1 | Core released and initialisation complete |

## Verification
All outputs are registered from the next state, so every response appears one clock edge after the cycle that causes it. A change of the run bit shows at the first edge that samples the new level. Each timed release lands at the edge of the Nth strobe counted from the cycle after that change. The driver sets inputs on the falling edge and queues each expected output vector, tagged with the clock count at which it is due. The monitor compares them on the following falling edge, so each check sits exactly one edge after the stimulus it depends on. Idle cycles without strobes are placed inside every waiting phase to show that no count moves on the system clock alone.

// File: rtl/codec_rst_pkg.sv
package codec_rst_pkg;

    typedef enum logic [2:0] {
        PH_DOWN,
        PH_EXIT_WAIT,
        PH_INIT,
        PH_RUN,
        PH_ENTRY_WAIT
    } phase_t;

    typedef enum logic [1:0] {
        ZF_HOLD,
        ZF_WAIT,
        ZF_CLEAR
    } zflag_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/soft_edge_det.sv
module soft_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_run,
    output logic went_hi,
    output logic went_lo
);

    logic run_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_seen <= 1'b0;
        else        run_seen <= soft_run;
    end

    assign went_hi = soft_run & ~run_seen;
    assign went_lo = ~soft_run & run_seen;

    // R9
    edge_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        went_hi |=> !went_hi);

endmodule

// File: rtl/frame_cnt.sv
module frame_cnt #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [WIDTH-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (adv) count <= count + 1'b1;
    end

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(count));

endmodule

// File: rtl/zflag_timer.sv
module zflag_timer
    import codec_rst_pkg::*;
#(
    parameter int unsigned REL_FRAMES = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic went_hi,
    input  logic went_lo,
    input  logic frame_stb,
    output logic flag
);

    localparam int unsigned CW = $clog2(REL_FRAMES + 1);

    zflag_t         zf_q, zf_nxt;
    logic [CW-1:0]  rel_cnt;
    logic           cnt_adv;

    assign cnt_adv = frame_stb && (zf_q == ZF_WAIT);

    frame_cnt #(.WIDTH(CW)) u_rel_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (went_hi | went_lo),
        .adv   (cnt_adv),
        .count (rel_cnt)
    );

    always_comb begin
        zf_nxt = zf_q;
        unique case (zf_q)
            ZF_HOLD:  if (went_hi) zf_nxt = ZF_WAIT;
            ZF_WAIT: begin
                if (went_lo) zf_nxt = ZF_HOLD;
                else if (frame_stb && rel_cnt == CW'(REL_FRAMES - 1)) zf_nxt = ZF_CLEAR;
            end
            ZF_CLEAR: if (went_lo) zf_nxt = ZF_HOLD;
            default:  zf_nxt = ZF_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zf_q <= ZF_HOLD;
        else        zf_q <= zf_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b1;
        else        flag <= (zf_nxt != ZF_CLEAR);
    end

    // R6
    flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        went_lo |=> flag);

    // R7
    flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(frame_stb));

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import codec_rst_pkg::*;
#(
    parameter int unsigned ENTRY_FRAMES = 5,
    parameter int unsigned EXIT_FRAMES  = 2,
    parameter int unsigned INIT_FRAMES  = 516
) (
    input  logic clk,
    input  logic rst_n,
    input  logic went_hi,
    input  logic went_lo,
    input  logic frame_stb,
    output logic core_rst_n,
    output logic init_busy,
    output logic zero_force,
    output logic sdo_low,
    output logic ready
);

    localparam int unsigned DLY_MAX = max2(ENTRY_FRAMES, EXIT_FRAMES);
    localparam int unsigned DLY_W   = $clog2(DLY_MAX + 1);
    localparam int unsigned INIT_W  = $clog2(INIT_FRAMES + 1);

    phase_t             ph_q, ph_nxt;
    logic [DLY_W-1:0]   dly_cnt;
    logic [INIT_W-1:0]  init_cnt;
    logic               dly_adv, init_clr, init_adv, init_done;

    assign dly_adv   = frame_stb && ((ph_q == PH_EXIT_WAIT) || (ph_q == PH_ENTRY_WAIT));
    assign init_clr  = (ph_q == PH_EXIT_WAIT) && (ph_nxt == PH_INIT);
    assign init_adv  = frame_stb && (ph_q == PH_INIT) && !went_lo;
    assign init_done = (init_cnt == INIT_W'(INIT_FRAMES));

    frame_cnt #(.WIDTH(DLY_W)) u_dly_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (went_hi | went_lo),
        .adv   (dly_adv),
        .count (dly_cnt)
    );

    frame_cnt #(.WIDTH(INIT_W)) u_init_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (init_clr),
        .adv   (init_adv),
        .count (init_cnt)
    );

    always_comb begin
        ph_nxt = ph_q;
        unique case (ph_q)
            PH_DOWN: if (went_hi) ph_nxt = PH_EXIT_WAIT;
            PH_EXIT_WAIT: begin
                if (went_lo) ph_nxt = PH_DOWN;
                else if (frame_stb && dly_cnt == DLY_W'(EXIT_FRAMES - 1)) ph_nxt = PH_INIT;
            end
            PH_INIT: begin
                if (went_lo) ph_nxt = PH_ENTRY_WAIT;
                else if (frame_stb && init_cnt == INIT_W'(INIT_FRAMES - 1)) ph_nxt = PH_RUN;
            end
            PH_RUN: if (went_lo) ph_nxt = PH_ENTRY_WAIT;
            PH_ENTRY_WAIT: begin
                if (went_hi) ph_nxt = init_done ? PH_RUN : PH_INIT;
                else if (frame_stb && dly_cnt == DLY_W'(ENTRY_FRAMES - 1)) ph_nxt = PH_DOWN;
            end
            default: ph_nxt = PH_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_DOWN;
        else        ph_q <= ph_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_rst_n <= 1'b0;
            init_busy  <= 1'b0;
            zero_force <= 1'b1;
            sdo_low    <= 1'b1;
            ready      <= 1'b0;
        end else begin
            core_rst_n <= (ph_nxt == PH_INIT) || (ph_nxt == PH_RUN) || (ph_nxt == PH_ENTRY_WAIT);
            init_busy  <= (ph_nxt == PH_INIT) ||
                          ((ph_nxt == PH_ENTRY_WAIT) &&
                           ((ph_q == PH_INIT) || ((ph_q == PH_ENTRY_WAIT) && init_busy)));
            zero_force <= (ph_nxt != PH_RUN);
            sdo_low    <= (ph_nxt == PH_DOWN) || (ph_nxt == PH_EXIT_WAIT);
            ready      <= (ph_nxt == PH_RUN);
        end
    end

    // R2
    core_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_n) |-> $past(frame_stb));

    // R3
    core_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> $past(frame_stb));

    // R4
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(frame_stb) || $past(went_hi)));

    // R8
    sdo_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_low != core_rst_n);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && !went_hi && !went_lo) |=> ($stable(core_rst_n) && $stable(ready) && $stable(init_busy)));

    // R11
    ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (core_rst_n && !init_busy && !zero_force));

endmodule

// File: rtl/codec_rst_seq.sv
module codec_rst_seq
    import codec_rst_pkg::*;
#(
    parameter int unsigned ENTRY_FRAMES = 5,
    parameter int unsigned EXIT_FRAMES  = 2,
    parameter int unsigned INIT_FRAMES  = 516,
    parameter int unsigned ZF_FRAMES    = 7,
    parameter int unsigned NUM_ZFLAGS   = 2
) (
    input  logic                  clk,
    input  logic                  hard_rst_n,
    input  logic                  soft_run,
    input  logic                  frame_stb,
    output logic                  core_rst_n,
    output logic                  adc_init_busy,
    output logic                  adc_zero_force,
    output logic [NUM_ZFLAGS-1:0] zero_flag,
    output logic                  sdo_force_low,
    output logic                  core_ready
);

    logic went_hi, went_lo;

    soft_edge_det u_edge (
        .clk      (clk),
        .rst_n    (hard_rst_n),
        .soft_run (soft_run),
        .went_hi  (went_hi),
        .went_lo  (went_lo)
    );

    phase_fsm #(
        .ENTRY_FRAMES (ENTRY_FRAMES),
        .EXIT_FRAMES  (EXIT_FRAMES),
        .INIT_FRAMES  (INIT_FRAMES)
    ) u_phase (
        .clk        (clk),
        .rst_n      (hard_rst_n),
        .went_hi    (went_hi),
        .went_lo    (went_lo),
        .frame_stb  (frame_stb),
        .core_rst_n (core_rst_n),
        .init_busy  (adc_init_busy),
        .zero_force (adc_zero_force),
        .sdo_low    (sdo_force_low),
        .ready      (core_ready)
    );

    for (genvar gi = 0; gi < NUM_ZFLAGS; gi++) begin : g_zflag
        zflag_timer #(.REL_FRAMES(ZF_FRAMES)) u_zf (
            .clk       (clk),
            .rst_n     (hard_rst_n),
            .went_hi   (went_hi),
            .went_lo   (went_lo),
            .frame_stb (frame_stb),
            .flag      (zero_flag[gi])
        );
    end

    // R5
    zero_force_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (!core_ready) |-> adc_zero_force);

endmodule

// File: tb/codec_rst_seq_test.sv
`timescale 1ns/1ps
module codec_rst_seq_test;

    logic       clk = 1'b0;
    logic       hard_rst_n = 1'b0;
    logic       soft_run = 1'b0;
    logic       frame_stb = 1'b0;
    logic       core_rst_n, adc_init_busy, adc_zero_force, sdo_force_low, core_ready;
    logic [1:0] zero_flag;

    // vector: {core_rst_n, busy, zero_force, zflag[1], zflag[0], sdo_low, ready}
    localparam logic [6:0] V_DOWN    = 7'b0011110;
    localparam logic [6:0] V_INIT_ZH = 7'b1111100;
    localparam logic [6:0] V_INIT    = 7'b1110000;
    localparam logic [6:0] V_RUN     = 7'b1000001;
    localparam logic [6:0] V_ENT_RUN = 7'b1011100;
    localparam logic [6:0] V_RUN_ZH  = 7'b1001101;

    typedef struct {
        int         due;
        logic [6:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    codec_rst_seq uut (
        .clk            (clk),
        .hard_rst_n     (hard_rst_n),
        .soft_run       (soft_run),
        .frame_stb      (frame_stb),
        .core_rst_n     (core_rst_n),
        .adc_init_busy  (adc_init_busy),
        .adc_zero_force (adc_zero_force),
        .zero_flag      (zero_flag),
        .sdo_force_low  (sdo_force_low),
        .core_ready     (core_ready)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t       it;
            logic [6:0]  obs;
            it  = sb.pop_front();
            obs = {core_rst_n, adc_init_busy, adc_zero_force, zero_flag, sdo_force_low, core_ready};
            checks++;
            if (obs !== it.exp) begin
                fails++;
                $display("FAIL %s at cycle %0d: actual %b expected %b", it.tag, cyc, obs, it.exp);
            end
        end
    end

    task automatic step(input logic s, input logic f);
        soft_run  = s;
        frame_stb = f;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step_exp(input logic s, input logic f, input string tag, input logic [6:0] e);
        item_t it;
        it.due = cyc + 1;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        step(s, f);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step(1'b0, 1'b0);
        hard_rst_n = 1'b1;
        // R1 reset state
        step_exp(0, 0, "R1", V_DOWN);
        // R10 strobes in power-down with steady bit
        step_exp(0, 1, "R10", V_DOWN);
        step_exp(0, 1, "R10", V_DOWN);

        // R3 exit: strobe in change cycle not counted
        step_exp(1, 1, "R3", V_DOWN);
        step_exp(1, 0, "R10", V_DOWN);
        step_exp(1, 0, "R10", V_DOWN);
        step_exp(1, 1, "R3", V_DOWN);
        step_exp(1, 1, "R3", V_INIT_ZH);
        // R7 flags through strobes 3..6, drop on 7th
        for (int i = 0; i < 4; i++) step_exp(1, 1, "R7", V_INIT_ZH);
        step_exp(1, 1, "R7", V_INIT);
        step_exp(1, 0, "R10", V_INIT);
        for (int i = 6; i < 515; i++) step(1, 1);
        step_exp(1, 1, "R4", V_INIT);
        // R4 R5 R11 normal operation on 516th init strobe
        step_exp(1, 1, "R4", V_RUN);
        step_exp(1, 1, "R11", V_RUN);

        // R6 / R2 entry
        step_exp(0, 0, "R6", V_ENT_RUN);
        for (int i = 0; i < 4; i++) step_exp(0, 1, "R2", V_ENT_RUN);
        step_exp(0, 1, "R2", V_DOWN);
        step_exp(0, 0, "R8", V_DOWN);

        // R9 restart of exit count
        step_exp(1, 0, "R9", V_DOWN);
        step_exp(1, 1, "R9", V_DOWN);
        step_exp(0, 0, "R9", V_DOWN);
        step_exp(1, 0, "R9", V_DOWN);
        step_exp(1, 1, "R9", V_DOWN);
        step_exp(1, 1, "R9", V_INIT_ZH);
        for (int i = 1; i <= 9; i++) step(1, 1);
        step_exp(1, 1, "R5", V_INIT);
        // R9 cancelled entry during init, count frozen then resumed
        step_exp(0, 0, "R9", V_INIT_ZH);
        for (int i = 0; i < 3; i++) step_exp(0, 1, "R9", V_INIT_ZH);
        step_exp(1, 0, "R9", V_INIT_ZH);
        for (int i = 11; i <= 16; i++) step_exp(1, 1, "R7", V_INIT_ZH);
        step_exp(1, 1, "R7", V_INIT);
        for (int i = 18; i <= 514; i++) step(1, 1);
        step_exp(1, 1, "R9", V_INIT);
        step_exp(1, 1, "R9", V_RUN);

        // R9 cancelled entry from normal operation
        step_exp(0, 0, "R6", V_ENT_RUN);
        for (int i = 0; i < 5; i++) step_exp(0, 0, "R10", V_ENT_RUN);
        for (int i = 0; i < 4; i++) step_exp(0, 1, "R9", V_ENT_RUN);
        step_exp(1, 0, "R9", V_RUN_ZH);
        for (int i = 0; i < 6; i++) step_exp(1, 1, "R7", V_RUN_ZH);
        step_exp(1, 1, "R7", V_RUN);
        step_exp(1, 0, "R11", V_RUN);

        repeat (3) step(1, 0);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        report();
        $finish;
    end

endmodule